// File: doc/BRIEF.md
# ADC Scan Sequencer

This block lets one single-input SAR ADC cover sixteen external inputs. It places a 4-bit select on an external analog multiplexer and issues the conversion-start pulse to the converter. A 7-bit down-counter holds the scan position, and its low nibble is the select. The scan starts from channel 15 and ends at channel 0. The select steps down on the converter's acquisition-done pulse rather than on end-of-conversion. At that point the input is already held, so the multiplexer can move safely. The next start pulse goes out at the same moment. The converter keeps one pending start while it works, so the latency of the trigger path is hidden behind the running conversion.

One sweep of all sixteen inputs forms a sampling period. Firmware begins a period with a start strobe, which gives the first trigger. The hardware then issues the other fifteen triggers on its own. When channel 0 finishes acquiring, the trigger gate closes and the block raises a period-done flag. It then stays idle until firmware has drained the results and sent a reload strobe. The reload strobe re-arms the counter at its top value. Each acquisition also produces a one-cycle tag that names the channel just acquired, so the result storage can file the sample. At about 1 µs per channel, one period fits inside the 19 µs budget.

Top module: `scan_sequencer`

## Requirements
- R1: After reset the select reads 15 (the low four bits of the reload value 0x7F). The trigger, tag-valid and period-done outputs are all low, and the block waits for a firmware start.
- R2: A start strobe while waiting produces exactly one trigger pulse, one cycle wide, in the cycle after the strobe, and the scan begins. A start strobe during a scan or after the period has ended produces no trigger.
- R3: During a scan, each rising edge of the acquisition-done input sets tag-valid for one cycle with the tag equal to the channel that was selected, and lowers the select by one. An input held high for several cycles counts as one edge.
- R4: An acquisition edge on any channel other than 0 produces a trigger pulse in the same cycle as its tag.
- R5: An acquisition edge on channel 0 produces tag 0 and no trigger. It sets period-done, and the select stays at 0.
- R6: Acquisition edges that arrive while waiting for a start, or after period-done is set, produce no tag and no trigger and leave the select unchanged.
- R7: A reload strobe returns the select to 15, clears period-done, blocks any tag or trigger in the next cycle, and returns the block to waiting for a start. This also applies when the strobe arrives in the middle of a period, which aborts the scan.
- R8: When a reload strobe and an acquisition edge arrive in the same cycle, the reload takes effect and the acquisition edge is dropped.
- R9: A full period from start to period-done issues exactly 16 trigger pulses: one from firmware and fifteen from hardware.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are synchronous to it |
| rst | input | 1 | Synchronous reset, active high |
| acq_done_i | input | 1 | Acquisition-done level from the ADC; its rising edge is used |
| fw_start_i | input | 1 | Firmware strobe that starts a period |
| fw_reload_i | input | 1 | Firmware strobe that reloads the counter and re-arms the gate |
| chan_sel_o | output | 4 | Select lines to the analog multiplexer |
| adc_trig_o | output | 1 | One-cycle conversion-start pulse |
| tag_chan_o | output | 4 | Channel that has just been acquired |
| tag_valid_o | output | 1 | Qualifies tag_chan_o for one cycle |
| period_done_o | output | 1 | Set when channel 0 has been acquired; cleared by reload |

## Verification
The risky overlap is a reload strobe and a fresh acquisition edge landing in the same clock cycle. If the two are handled wrongly, the counter is both reloaded and decremented, or a stray tag and trigger escape from an aborted scan. The bench sets up a running scan a few channels deep, then raises the acquisition input and the reload strobe on the same falling edge. In the following cycle it requires the select at 15, no tag, no trigger and no period-done. A later firmware start must then produce a trigger, which shows the gate was re-armed. A scoreboard queue of expected tag and trigger pairs catches any tag that the dropped edge might have let through.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

    // Width of the position counter and of the multiplexer select
    localparam int unsigned SEQ_CNT_W = 7;
    localparam int unsigned SEQ_SEL_W = 4;
    localparam int unsigned SEQ_NUM_CH = 1 << SEQ_SEL_W;

    // Default value loaded into the counter at reset and on reload
    localparam logic [SEQ_CNT_W-1:0] SEQ_RELOAD_DEF = 7'h7F;

    // Scan control states
    typedef enum logic [1:0] {
        SEQ_ARMED = 2'd0,   // gate open, waiting for firmware start
        SEQ_RUN   = 2'd1,   // hardware stepping through channels
        SEQ_HALT  = 2'd2    // period complete, gate closed
    } seq_state_e;

    // Per-sample channel tag
    typedef struct packed {
        logic                 valid;
        logic [SEQ_SEL_W-1:0] chan;
    } seq_tag_t;

    // Select field taken from the counter
    function automatic logic [SEQ_SEL_W-1:0] sel_of(input logic [SEQ_CNT_W-1:0] cnt);
        return cnt[SEQ_SEL_W-1:0];
    endfunction

endpackage

// File: rtl/seq_edge_detect.sv
module seq_edge_detect #(
    parameter logic RESET_LEVEL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic level_i,
    output logic rise_o
);

    logic level_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= RESET_LEVEL;
        end else begin
            level_q <= level_i;
        end
    end

    // One-cycle event on a low-to-high transition
    assign rise_o = level_i & ~level_q;

endmodule

// File: rtl/seq_chan_counter.sv
module seq_chan_counter
    import scan_seq_pkg::*;
#(
    parameter logic [SEQ_CNT_W-1:0] RELOAD_VAL = SEQ_RELOAD_DEF
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load_i,
    input  logic                 dec_i,
    output logic [SEQ_SEL_W-1:0] sel_o,
    output logic                 at_zero_o
);

    logic [SEQ_CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || load_i) begin
            cnt_q <= RELOAD_VAL;
        end else if (dec_i) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign sel_o     = sel_of(cnt_q);
    assign at_zero_o = (sel_of(cnt_q) == '0);

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
    import scan_seq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start_i,
    input  logic                 reload_i,
    input  logic                 acq_evt_i,
    input  logic [SEQ_SEL_W-1:0] sel_i,
    input  logic                 at_zero_i,
    output logic                 dec_o,
    output logic                 trig_o,
    output seq_tag_t             tag_o,
    output logic                 done_o
);

    seq_state_e state_q, state_d;
    logic       trig_q, trig_d;
    seq_tag_t   tag_q, tag_d;

    always_comb begin
        state_d = state_q;
        dec_o   = 1'b0;
        trig_d  = 1'b0;
        tag_d   = '0;
        if (reload_i) begin
            // Reload overrides everything, including a coincident edge
            state_d = SEQ_ARMED;
        end else begin
            unique case (state_q)
                SEQ_ARMED: begin
                    if (start_i) begin
                        trig_d  = 1'b1;
                        state_d = SEQ_RUN;
                    end
                end
                SEQ_RUN: begin
                    if (acq_evt_i) begin
                        tag_d.valid = 1'b1;
                        tag_d.chan  = sel_i;
                        if (at_zero_i) begin
                            // Last channel: close the gate, hold position
                            state_d = SEQ_HALT;
                        end else begin
                            dec_o  = 1'b1;
                            trig_d = 1'b1;
                        end
                    end
                end
                SEQ_HALT: begin
                    state_d = SEQ_HALT;
                end
                default: begin
                    state_d = SEQ_ARMED;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_ARMED;
            trig_q  <= 1'b0;
            tag_q   <= '0;
        end else begin
            state_q <= state_d;
            trig_q  <= trig_d;
            tag_q   <= tag_d;
        end
    end

    assign trig_o = trig_q;
    assign tag_o  = tag_q;
    assign done_o = (state_q == SEQ_HALT);

endmodule

// File: rtl/scan_sequencer.sv
module scan_sequencer
    import scan_seq_pkg::*;
#(
    parameter logic [SEQ_CNT_W-1:0] RELOAD_VAL = SEQ_RELOAD_DEF
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 acq_done_i,
    input  logic                 fw_start_i,
    input  logic                 fw_reload_i,
    output logic [SEQ_SEL_W-1:0] chan_sel_o,
    output logic                 adc_trig_o,
    output logic [SEQ_SEL_W-1:0] tag_chan_o,
    output logic                 tag_valid_o,
    output logic                 period_done_o
);

    logic     acq_evt;
    logic     dec;
    logic     at_zero;
    seq_tag_t tag;

    seq_edge_detect #(
        .RESET_LEVEL(1'b0)
    ) u_acq_edge (
        .clk     (clk),
        .rst     (rst),
        .level_i (acq_done_i),
        .rise_o  (acq_evt)
    );

    seq_chan_counter #(
        .RELOAD_VAL(RELOAD_VAL)
    ) u_counter (
        .clk       (clk),
        .rst       (rst),
        .load_i    (fw_reload_i),
        .dec_i     (dec),
        .sel_o     (chan_sel_o),
        .at_zero_o (at_zero)
    );

    seq_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start_i   (fw_start_i),
        .reload_i  (fw_reload_i),
        .acq_evt_i (acq_evt),
        .sel_i     (chan_sel_o),
        .at_zero_i (at_zero),
        .dec_o     (dec),
        .trig_o    (adc_trig_o),
        .tag_o     (tag),
        .done_o    (period_done_o)
    );

    assign tag_chan_o  = tag.chan;
    assign tag_valid_o = tag.valid;

endmodule

// File: rtl/scan_seq_checker.sv
module scan_seq_checker
    import scan_seq_pkg::*;
#(
    parameter logic [SEQ_CNT_W-1:0] RELOAD_VAL = SEQ_RELOAD_DEF
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 fw_reload_i,
    input logic [SEQ_SEL_W-1:0] chan_sel_o,
    input logic                 adc_trig_o,
    input logic [SEQ_SEL_W-1:0] tag_chan_o,
    input logic                 tag_valid_o,
    input logic                 period_done_o
);

    localparam logic [SEQ_SEL_W-1:0] TOP_CH = RELOAD_VAL[SEQ_SEL_W-1:0];

    // R3: a tag on a nonzero channel leaves the select one below it
    assert_sel_step_R3: assert property (@(posedge clk) disable iff (rst)
        (tag_valid_o && tag_chan_o != '0) |-> (chan_sel_o == tag_chan_o - 1'b1));

    // R4: every nonzero-channel tag comes with a trigger
    assert_trig_follows_R4: assert property (@(posedge clk) disable iff (rst)
        (tag_valid_o && tag_chan_o != '0) |-> adc_trig_o);

    // R5: the channel-0 tag ends the period without a trigger
    assert_last_no_trig_R5: assert property (@(posedge clk) disable iff (rst)
        (tag_valid_o && tag_chan_o == '0) |-> (!adc_trig_o && period_done_o && chan_sel_o == '0));

    // R6: once halted, nothing is issued until a reload
    assert_halt_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        (period_done_o && !fw_reload_i) |=> (!adc_trig_o && !tag_valid_o && chan_sel_o == '0));

    // R7: a reload returns to the top channel and clears the flag
    assert_reload_R7: assert property (@(posedge clk) disable iff (rst)
        fw_reload_i |=> (chan_sel_o == TOP_CH && !period_done_o && !tag_valid_o && !adc_trig_o));

endmodule

bind scan_sequencer scan_seq_checker #(
    .RELOAD_VAL(RELOAD_VAL)
) u_scan_seq_checker (
    .clk           (clk),
    .rst           (rst),
    .fw_reload_i   (fw_reload_i),
    .chan_sel_o    (chan_sel_o),
    .adc_trig_o    (adc_trig_o),
    .tag_chan_o    (tag_chan_o),
    .tag_valid_o   (tag_valid_o),
    .period_done_o (period_done_o)
);

// File: tb/scan_sequencer_bench.sv
module scan_sequencer_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       acq_done_i = 1'b0;
    logic       fw_start_i = 1'b0;
    logic       fw_reload_i = 1'b0;
    logic [3:0] chan_sel_o;
    logic       adc_trig_o;
    logic [3:0] tag_chan_o;
    logic       tag_valid_o;
    logic       period_done_o;

    int errors = 0;
    int checks = 0;
    int trig_count = 0;
    bit finished = 1'b0;

    // Scoreboard entry: {expected trigger, expected channel}
    logic [4:0] exp_q[$];

    always #2 clk = ~clk;   // 250 MHz

    scan_sequencer u_scan_sequencer (
        .clk           (clk),
        .rst           (rst),
        .acq_done_i    (acq_done_i),
        .fw_start_i    (fw_start_i),
        .fw_reload_i   (fw_reload_i),
        .chan_sel_o    (chan_sel_o),
        .adc_trig_o    (adc_trig_o),
        .tag_chan_o    (tag_chan_o),
        .tag_valid_o   (tag_valid_o),
        .period_done_o (period_done_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: compares each produced tag against the scoreboard and counts triggers
    always @(negedge clk) begin
        if (!rst) begin
            if (adc_trig_o) trig_count++;
            if (tag_valid_o) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6/R8 unexpected tag", int'(tag_chan_o), -1);
                end else begin
                    logic [4:0] e;
                    e = exp_q.pop_front();
                    check(tag_chan_o == e[3:0], "R3 tag channel", int'(tag_chan_o), int'(e[3:0]));
                    check(adc_trig_o == e[4], "R4/R5 trigger with tag", int'(adc_trig_o), int'(e[4]));
                end
            end
        end
    end

    // Driver: one acquisition pulse held for hold cycles, with its expectation queued
    task automatic acq_pulse(input int hold, input bit expect_tag, input logic [4:0] item);
        if (expect_tag) exp_q.push_back(item);
        @(negedge clk) acq_done_i = 1'b1;
        repeat (hold) @(negedge clk);
        acq_done_i = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic strobe_start();
        @(negedge clk) fw_start_i = 1'b1;
        @(negedge clk) fw_start_i = 1'b0;
    endtask

    task automatic strobe_reload();
        @(negedge clk) fw_reload_i = 1'b1;
        @(negedge clk) fw_reload_i = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(chan_sel_o == 4'd15, "R1 select", chan_sel_o, 15);
        check(!adc_trig_o && !tag_valid_o && !period_done_o, "R1 outputs low",
              {adc_trig_o, tag_valid_o, period_done_o}, 0);

        // R6: acquisition while waiting is ignored
        acq_pulse(1, 1'b0, 5'd0);
        check(chan_sel_o == 4'd15, "R6 armed ignore", chan_sel_o, 15);

        // R2: firmware start gives one trigger pulse
        trig_count = 0;
        @(negedge clk) fw_start_i = 1'b1;
        @(negedge clk) fw_start_i = 1'b0;
        check(adc_trig_o == 1'b1, "R2 start trigger", adc_trig_o, 1);
        @(negedge clk);
        check(adc_trig_o == 1'b0, "R2 pulse width", adc_trig_o, 0);
        strobe_start();
        check(adc_trig_o == 1'b0, "R2 start ignored while running", adc_trig_o, 0);

        // R3: held-high acquisition counts once
        acq_pulse(4, 1'b1, {1'b1, 4'd15});
        check(chan_sel_o == 4'd14, "R3 held edge", chan_sel_o, 14);

        for (int c = 14; c >= 1; c--) begin
            acq_pulse((c % 3) + 1, 1'b1, {1'b1, 4'(c)});
            check(chan_sel_o == 4'(c - 1), "R3 step", chan_sel_o, c - 1);
        end

        // R5: last channel ends the period
        acq_pulse(1, 1'b1, {1'b0, 4'd0});
        check(period_done_o == 1'b1, "R5 done set", period_done_o, 1);
        check(chan_sel_o == 4'd0, "R5 select held", chan_sel_o, 0);
        check(trig_count == 16, "R9 triggers per period", trig_count, 16);

        // R6: halted, acquisition and start ignored
        acq_pulse(2, 1'b0, 5'd0);
        check(chan_sel_o == 4'd0 && period_done_o, "R6 halt ignore", chan_sel_o, 0);
        trig_count = 0;
        strobe_start();
        @(negedge clk);
        check(trig_count == 0, "R2 start ignored when halted", trig_count, 0);

        // R7: reload re-arms
        strobe_reload();
        check(chan_sel_o == 4'd15, "R7 reload select", chan_sel_o, 15);
        check(period_done_o == 1'b0, "R7 done cleared", period_done_o, 0);

        // R7: mid-period abort
        strobe_start();
        acq_pulse(1, 1'b1, {1'b1, 4'd15});
        acq_pulse(1, 1'b1, {1'b1, 4'd14});
        acq_pulse(1, 1'b1, {1'b1, 4'd13});
        check(chan_sel_o == 4'd12, "R3 before abort", chan_sel_o, 12);
        strobe_reload();
        check(chan_sel_o == 4'd15 && !period_done_o, "R7 abort", chan_sel_o, 15);
        acq_pulse(1, 1'b0, 5'd0);
        check(chan_sel_o == 4'd15, "R7 armed after abort", chan_sel_o, 15);

        // R8: reload and acquisition edge in the same cycle
        strobe_start();
        acq_pulse(1, 1'b1, {1'b1, 4'd15});
        acq_pulse(1, 1'b1, {1'b1, 4'd14});
        @(negedge clk);
        acq_done_i  = 1'b1;
        fw_reload_i = 1'b1;
        @(negedge clk);
        acq_done_i  = 1'b0;
        fw_reload_i = 1'b0;
        check(!tag_valid_o && !adc_trig_o, "R8 edge dropped", {tag_valid_o, adc_trig_o}, 0);
        check(chan_sel_o == 4'd15 && !period_done_o, "R8 reload wins", chan_sel_o, 15);
        @(negedge clk) fw_start_i = 1'b1;
        @(negedge clk) fw_start_i = 1'b0;
        check(adc_trig_o == 1'b1, "R8 re-armed start", adc_trig_o, 1);
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule